// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the transfers of one DMA channel. It is loaded from a parallel configuration: an element count per frame, a frame count per block, two frame-index values (one per side) of which one serves as the packet length, a request selector and three synchronisation flags (frame-sync, block-sync and source-sync). Once enabled, the block counts transfer strobes. It tracks the element, frame and packet positions and raises per-channel status flags. At each synchronisation boundary it decides whether the channel stays active or drops out and waits for the next request.

The selected request line is level sensitive. A rising level activates an enabled channel that is idle. If the channel is already active, the rise is recorded as pending. The three synchronisation granularities end an active burst at different points. With element sync, the burst ends after every element. With frame sync, it ends at the end of each frame. With packet sync (frame-sync and block-sync both set), it ends when the packet counter wraps. An unsynchronised channel runs from enable to the end of the block without stopping.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, ch_enabled, ch_active, load_err, status, elem_idx, frame_idx and pkt_idx are all zero.
- R2: A ch_enable pulse with non-zero counts sets ch_enabled and latches the element count, frame count and packet length. It also zeroes the three indices. The packet length is cfg_dst_fidx when cfg_src_sync is 0 and cfg_src_fidx when it is 1.
- R3: A ch_enable pulse with a zero element count or a zero frame count leaves ch_enabled and ch_active at 0 and pulses load_err for one cycle.
- R4: A cfg_sync_sel value of 0 means unsynchronised. Values 1..63 select req_vec[cfg_sync_sel], and values of 64 and above select no line. At enable the channel becomes active at once if it is unsynchronised or its selected line is high. Otherwise it becomes active on a later rise of that line.
- R5: xfer_done advances elem_idx only while ch_active is 1. In any other cycle it changes nothing.
- R6: When elem_idx would reach the element count, it wraps to 0 and frame_idx increments, and status bit 3 is set. Status bit 2 is set when elem_idx reaches the element count divided by two (rounded down).
- R7: With frame-sync and block-sync both set, each element advances pkt_idx, which wraps to 0 on reaching the packet length. The wrap sets status bit 7 only when cfg_src_sync is 0. On a synchronised channel the wrap is a deactivation attempt.
- R8: On a synchronised channel, an attempt happens after every element when frame-sync and block-sync are both 0. It happens at each frame end when frame-sync is 1 and block-sync is 0.
- R9: At a deactivation attempt the channel stays active if a request rise was seen while active, including in the same cycle, and that pending mark is then cleared. Failing that, it stays active if the selected line is high. Otherwise ch_active falls.
- R10: When frame_idx would reach frame_count − 1, status bit 4 is set. After the last element of the last frame, status bit 5 is set, ch_enabled and ch_active fall and all indices return to 0.
- R11: A status bit is set only if the same bit of cfg_irq_en is 1. Bit 6 marks a request rise while enabled. Bit 8 marks xfer_err while active and bit 11 marks xfer_misalign while active. status_clr clears bits write-one style, and a set in the same cycle wins.
- R12: ch_disable clears ch_enabled and ch_active and zeroes the indices, taking priority over ch_enable. ch_active is never 1 while ch_enabled is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_elem_cnt | input | 24 | Elements per frame |
| cfg_frame_cnt | input | 16 | Frames per block |
| cfg_src_fidx | input | 16 | Source-side frame index, packet length when source-sync |
| cfg_dst_fidx | input | 16 | Destination-side frame index, packet length otherwise |
| cfg_sync_sel | input | 7 | Request line selector, 0 = unsynchronised |
| cfg_frame_sync | input | 1 | Frame synchronisation flag |
| cfg_block_sync | input | 1 | Block synchronisation flag |
| cfg_src_sync | input | 1 | Source-side synchronisation flag |
| cfg_irq_en | input | 12 | Per-bit status enable |
| ch_enable | input | 1 | Enable pulse, loads the working set |
| ch_disable | input | 1 | Disable pulse |
| req_vec | input | 64 | Level-sensitive request lines |
| xfer_done | input | 1 | One element transferred |
| xfer_err | input | 1 | Transfer error event |
| xfer_misalign | input | 1 | Misalignment event |
| status_clr | input | 12 | Write-one-to-clear status mask |
| ch_enabled | output | 1 | Channel enabled |
| ch_active | output | 1 | Channel active |
| load_err | output | 1 | Illegal load pulse |
| status | output | 12 | Status flags |
| elem_idx | output | 24 | Current element index |
| frame_idx | output | 16 | Current frame index |
| pkt_idx | output | 16 | Current packet index |

## Verification
The sharpest collision is a rising request in the same cycle as a deactivation attempt. The rise must count as the pending mark and be consumed at once, so that it keeps the channel active for exactly that attempt. The bench drives the request high together with the strobe that ends an element-synchronised burst. It then drops the request for the next strobe and expects the channel to fall. A leftover pending mark would instead keep it active for one more element. A second collision puts a packet wrap on the same element as a frame end. The bench expects a single deactivation decision and both status bits in one cycle. A per-clock reference model judges both.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ST_W    = 12;
  localparam int B_HALF  = 2;
  localparam int B_FRAME = 3;
  localparam int B_LAST  = 4;
  localparam int B_BLOCK = 5;
  localparam int B_SYNC  = 6;
  localparam int B_PKT   = 7;
  localparam int B_TERR  = 8;
  localparam int B_MISAL = 11;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
  parameter int NREQ  = 64,
  parameter int SEL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_vec,
  input  logic [SEL_W-1:0] sel,
  output logic             synced,
  output logic             lvl,
  output logic             rise
);
  localparam int IDX_W = $clog2(NREQ);

  logic lvl_q;
  logic in_range;

  always_comb begin
    synced   = (sel != '0);
    in_range = ({1'b0, sel} < (SEL_W+1)'(NREQ));
    lvl      = synced && in_range && req_vec[sel[IDX_W-1:0]];
    rise     = lvl && !lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
  parameter int ELEM_W  = 24,
  parameter int FRAME_W = 16,
  parameter int PKT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clear,
  input  logic               step,
  input  logic               pkt_mode,
  input  logic [ELEM_W-1:0]  elem_cnt,
  input  logic [FRAME_W-1:0] frame_cnt,
  input  logic [PKT_W-1:0]   pkt_len,
  output logic [ELEM_W-1:0]  elem_idx,
  output logic [FRAME_W-1:0] frame_idx,
  output logic [PKT_W-1:0]   pkt_idx,
  output logic               ev_half,
  output logic               ev_frame,
  output logic               ev_last,
  output logic               ev_block,
  output logic               ev_pkt
);
  logic [ELEM_W-1:0]  elim_q, elim_d, elem_q, elem_d, e_inc;
  logic [FRAME_W-1:0] flim_q, flim_d, frame_q, frame_d, f_inc;
  logic [PKT_W-1:0]   plim_q, plim_d, pkt_q, pkt_d, p_inc;

  always_comb begin
    e_inc    = elem_q + 1'b1;
    f_inc    = frame_q + 1'b1;
    p_inc    = pkt_q + 1'b1;
    ev_frame = step && (e_inc == elim_q);
    ev_half  = step && (e_inc == (elim_q >> 1));
    ev_block = ev_frame && (f_inc == flim_q);
    ev_last  = ev_frame && (f_inc == flim_q - 1'b1);
    ev_pkt   = step && pkt_mode && (p_inc == plim_q);

    elim_d  = elim_q;
    flim_d  = flim_q;
    plim_d  = plim_q;
    elem_d  = elem_q;
    frame_d = frame_q;
    pkt_d   = pkt_q;
    if (load) begin
      elim_d  = elem_cnt;
      flim_d  = frame_cnt;
      plim_d  = pkt_len;
      elem_d  = '0;
      frame_d = '0;
      pkt_d   = '0;
    end else if (clear) begin
      elem_d  = '0;
      frame_d = '0;
      pkt_d   = '0;
    end else if (step) begin
      elem_d  = ev_frame ? '0 : e_inc;
      frame_d = ev_frame ? f_inc : frame_q;
      if (pkt_mode) pkt_d = ev_pkt ? '0 : p_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elim_q  <= '0;
      flim_q  <= '0;
      plim_q  <= '0;
      elem_q  <= '0;
      frame_q <= '0;
      pkt_q   <= '0;
    end else begin
      elim_q  <= elim_d;
      flim_q  <= flim_d;
      plim_q  <= plim_d;
      elem_q  <= elem_d;
      frame_q <= frame_d;
      pkt_q   <= pkt_d;
    end
  end

  assign elem_idx  = elem_q;
  assign frame_idx = frame_q;
  assign pkt_idx   = pkt_q;

  AST_ELEM_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (elim_q != '0) |-> (elem_q < elim_q)); // R6
  AST_FRAME_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (flim_q != '0) |-> (frame_q < flim_q)); // R10
endmodule

// File: rtl/dma_seq_stat.sv
module dma_seq_stat #(
  parameter int ST_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] mask,
  input  logic [ST_W-1:0] clr,
  output logic [ST_W-1:0] st
);
  logic [ST_W-1:0] st_q, st_d;

  always_comb st_d = (st_q & ~clr) | (set_vec & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;

  for (genvar k = 0; k < ST_W; k++) begin : g_chk
    AST_MASKED_BIT_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q[k] && !mask[k]) |=> !st_q[k]); // R11
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq import dma_seq_pkg::*; #(
  parameter int ELEM_W  = 24,
  parameter int FRAME_W = 16,
  parameter int PKT_W   = 16,
  parameter int SEL_W   = 7,
  parameter int NREQ    = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ELEM_W-1:0]  cfg_elem_cnt,
  input  logic [FRAME_W-1:0] cfg_frame_cnt,
  input  logic [PKT_W-1:0]   cfg_src_fidx,
  input  logic [PKT_W-1:0]   cfg_dst_fidx,
  input  logic [SEL_W-1:0]   cfg_sync_sel,
  input  logic               cfg_frame_sync,
  input  logic               cfg_block_sync,
  input  logic               cfg_src_sync,
  input  logic [ST_W-1:0]    cfg_irq_en,
  input  logic               ch_enable,
  input  logic               ch_disable,
  input  logic [NREQ-1:0]    req_vec,
  input  logic               xfer_done,
  input  logic               xfer_err,
  input  logic               xfer_misalign,
  input  logic [ST_W-1:0]    status_clr,
  output logic               ch_enabled,
  output logic               ch_active,
  output logic               load_err,
  output logic [ST_W-1:0]    status,
  output logic [ELEM_W-1:0]  elem_idx,
  output logic [FRAME_W-1:0] frame_idx,
  output logic [PKT_W-1:0]   pkt_idx
);
  logic rs1_q, rs2_q, rst_s_n;
  logic en_q, en_d, act_q, act_d, pend_q, pend_d, lerr_q, lerr_d;
  logic synced, lvl, rise;
  logic legal, do_load, step, pkt_mode, pend_eff, deact_try, cnt_clear;
  logic ev_half, ev_frame, ev_last, ev_block, ev_pkt;
  logic [PKT_W-1:0] pkt_len;
  logic [ST_W-1:0]  st_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs1_q, rs2_q} <= 2'b00;
    else        {rs1_q, rs2_q} <= {1'b1, rs1_q};
  end
  assign rst_s_n = rs2_q;

  dma_req_sel #(.NREQ(NREQ), .SEL_W(SEL_W)) u_req (
    .clk(clk), .rst_n(rst_s_n), .req_vec(req_vec), .sel(cfg_sync_sel),
    .synced(synced), .lvl(lvl), .rise(rise));

  always_comb begin
    legal     = (cfg_elem_cnt != '0) && (cfg_frame_cnt != '0);
    do_load   = ch_enable && !ch_disable && legal;
    step      = xfer_done && act_q && !ch_enable && !ch_disable;
    pkt_mode  = cfg_frame_sync && cfg_block_sync;
    pkt_len   = cfg_src_sync ? cfg_src_fidx : cfg_dst_fidx;
    cnt_clear = ch_disable || ev_block;
  end

  dma_seq_cnt #(.ELEM_W(ELEM_W), .FRAME_W(FRAME_W), .PKT_W(PKT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .load(do_load), .clear(cnt_clear), .step(step),
    .pkt_mode(pkt_mode), .elem_cnt(cfg_elem_cnt), .frame_cnt(cfg_frame_cnt),
    .pkt_len(pkt_len), .elem_idx(elem_idx), .frame_idx(frame_idx), .pkt_idx(pkt_idx),
    .ev_half(ev_half), .ev_frame(ev_frame), .ev_last(ev_last), .ev_block(ev_block),
    .ev_pkt(ev_pkt));

  always_comb begin
    pend_eff  = pend_q || (rise && en_q && act_q);
    deact_try = step && synced &&
                (ev_pkt || (ev_frame && cfg_frame_sync && !cfg_block_sync) ||
                 (!cfg_frame_sync && !cfg_block_sync));
    en_d   = en_q;
    act_d  = act_q;
    pend_d = pend_q;
    lerr_d = 1'b0;
    if (ch_disable) begin
      en_d   = 1'b0;
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (ch_enable) begin
      pend_d = 1'b0;
      if (legal) begin
        en_d  = 1'b1;
        act_d = !synced || lvl;
      end else begin
        en_d   = 1'b0;
        act_d  = 1'b0;
        lerr_d = 1'b1;
      end
    end else if (en_q) begin
      if (ev_block) begin
        en_d   = 1'b0;
        act_d  = 1'b0;
        pend_d = 1'b0;
      end else if (deact_try) begin
        pend_d = 1'b0;
        if (!pend_eff && !lvl) act_d = 1'b0;
      end else begin
        if (rise && !act_q) act_d = 1'b1;
        pend_d = pend_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      lerr_q <= lerr_d;
    end
  end

  always_comb begin
    st_set          = '0;
    st_set[B_HALF]  = ev_half;
    st_set[B_FRAME] = ev_frame;
    st_set[B_LAST]  = ev_last;
    st_set[B_BLOCK] = ev_block;
    st_set[B_SYNC]  = rise && en_q;
    st_set[B_PKT]   = ev_pkt && !cfg_src_sync;
    st_set[B_TERR]  = xfer_err && act_q;
    st_set[B_MISAL] = xfer_misalign && act_q;
  end

  dma_seq_stat #(.ST_W(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_s_n), .set_vec(st_set), .mask(cfg_irq_en),
    .clr(status_clr), .st(status));

  assign ch_enabled = en_q;
  assign ch_active  = act_q;
  assign load_err   = lerr_q;

  AST_ZERO_LOAD_REJECTED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ch_enable && !ch_disable && !legal) |=> (!ch_enabled && load_err)); // R3
  AST_ACTIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    ch_active |-> ch_enabled); // R12
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_s_n)
    ch_disable |=> (!ch_active && !ch_enabled)); // R12
  AST_IDLE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ch_active && !ch_enable && !ch_disable) |=> $stable(elem_idx)); // R5
  AST_BLOCK_END_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_block && !ch_enable) |=> (!ch_enabled && !ch_active)); // R10
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
  localparam int NREQ = 64;

  logic        clk, rst_n;
  logic [23:0] cfg_elem_cnt;
  logic [15:0] cfg_frame_cnt, cfg_src_fidx, cfg_dst_fidx;
  logic [6:0]  cfg_sync_sel;
  logic        cfg_frame_sync, cfg_block_sync, cfg_src_sync;
  logic [11:0] cfg_irq_en, status_clr;
  logic        ch_enable, ch_disable, xfer_done, xfer_err, xfer_misalign;
  logic [NREQ-1:0] req_vec;
  logic        ch_enabled, ch_active, load_err;
  logic [11:0] status;
  logic [23:0] elem_idx;
  logic [15:0] frame_idx, pkt_idx;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  // reference model state
  int m_en, m_act, m_pend, m_lerr, m_lvlq, rst_stage;
  int m_elem, m_frame, m_pkt, m_E, m_F, m_P;
  logic [11:0] m_st;

  dma_chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt),
    .cfg_src_fidx(cfg_src_fidx), .cfg_dst_fidx(cfg_dst_fidx), .cfg_sync_sel(cfg_sync_sel),
    .cfg_frame_sync(cfg_frame_sync), .cfg_block_sync(cfg_block_sync),
    .cfg_src_sync(cfg_src_sync), .cfg_irq_en(cfg_irq_en), .ch_enable(ch_enable),
    .ch_disable(ch_disable), .req_vec(req_vec), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .xfer_misalign(xfer_misalign), .status_clr(status_clr), .ch_enabled(ch_enabled),
    .ch_active(ch_active), .load_err(load_err), .status(status), .elem_idx(elem_idx),
    .frame_idx(frame_idx), .pkt_idx(pkt_idx));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_act = 0; m_pend = 0; m_lerr = 0; m_lvlq = 0;
    m_elem = 0; m_frame = 0; m_pkt = 0; m_E = 0; m_F = 0; m_P = 0; m_st = '0;
  endtask

  task automatic model_step();
    int lvl, rise, stp, fend, blk, last, half, pk, pe, dtry, syn, legal, pmode;
    logic [11:0] sv;
    if (!rst_n) begin rst_stage = 0; model_reset(); return; end
    if (rst_stage < 2) begin rst_stage++; return; end
    syn   = (cfg_sync_sel != 0);
    lvl   = (syn && cfg_sync_sel < NREQ) ? int'(req_vec[cfg_sync_sel]) : 0;
    rise  = lvl && !m_lvlq;
    stp   = xfer_done && m_act && !ch_enable && !ch_disable;
    pmode = cfg_frame_sync && cfg_block_sync;
    fend  = stp && (m_elem + 1 == m_E);
    half  = stp && (m_elem + 1 == m_E / 2);
    blk   = fend && (m_frame + 1 == m_F);
    last  = fend && (m_frame + 1 == m_F - 1);
    pk    = stp && pmode && (m_pkt + 1 == m_P);
    legal = (cfg_elem_cnt != 0) && (cfg_frame_cnt != 0);
    pe    = m_pend || (rise && m_en && m_act);
    dtry  = stp && syn && (pk || (fend && cfg_frame_sync && !cfg_block_sync) ||
                           (!cfg_frame_sync && !cfg_block_sync));
    sv = '0;
    sv[2] = half; sv[3] = fend; sv[4] = last; sv[5] = blk;
    sv[6] = rise && m_en; sv[7] = pk && !cfg_src_sync;
    sv[8] = xfer_err && m_act; sv[11] = xfer_misalign && m_act;
    m_st = (m_st & ~status_clr) | (sv & cfg_irq_en);
    m_lerr = 0;
    if (ch_disable) begin
      m_en = 0; m_act = 0; m_pend = 0; m_elem = 0; m_frame = 0; m_pkt = 0;
    end else if (ch_enable) begin
      m_pend = 0;
      if (legal) begin
        m_en = 1; m_act = (!syn || lvl);
        m_E = cfg_elem_cnt; m_F = cfg_frame_cnt;
        m_P = cfg_src_sync ? cfg_src_fidx : cfg_dst_fidx;
        m_elem = 0; m_frame = 0; m_pkt = 0;
      end else begin
        m_en = 0; m_act = 0; m_lerr = 1;
      end
    end else if (m_en) begin
      if (stp) begin
        if (pmode) m_pkt = pk ? 0 : m_pkt + 1;
        if (fend) begin m_elem = 0; m_frame++; end
        else m_elem++;
      end
      if (blk) begin
        m_en = 0; m_act = 0; m_pend = 0; m_elem = 0; m_frame = 0; m_pkt = 0;
      end else if (dtry) begin
        if (!pe && !lvl) m_act = 0;
        m_pend = 0;
      end else begin
        if (rise && !m_act) m_act = 1;
        m_pend = pe;
      end
    end
    m_lvlq = lvl;
  endtask

  task automatic cmp_all();
    chk(cur_req, "ch_enabled", 64'(ch_enabled), 64'(m_en));
    chk(cur_req, "ch_active",  64'(ch_active),  64'(m_act));
    chk(cur_req, "load_err",   64'(load_err),   64'(m_lerr));
    chk(cur_req, "status",     64'(status),     64'(m_st));
    chk(cur_req, "elem_idx",   64'(elem_idx),   64'(m_elem));
    chk(cur_req, "frame_idx",  64'(frame_idx),  64'(m_frame));
    chk(cur_req, "pkt_idx",    64'(pkt_idx),    64'(m_pkt));
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic strobe(input int n = 1);
    for (int i = 0; i < n; i++) begin
      xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    end
  endtask

  task automatic setup(input int e, input int f, input int sel, input bit fs, input bit bs,
                       input bit ss);
    cfg_elem_cnt = 24'(e); cfg_frame_cnt = 16'(f); cfg_sync_sel = 7'(sel);
    cfg_frame_sync = fs; cfg_block_sync = bs; cfg_src_sync = ss;
    ch_enable = 1'b1; tick(); ch_enable = 1'b0;
  endtask

  task automatic stop();
    ch_disable = 1'b1; tick(); ch_disable = 1'b0;
    status_clr = 12'hFFF; tick(); status_clr = '0;
    req_vec = '0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_stage = 0; model_reset();
    cfg_elem_cnt = '0; cfg_frame_cnt = '0; cfg_src_fidx = 16'd3; cfg_dst_fidx = 16'd2;
    cfg_sync_sel = '0; cfg_frame_sync = 0; cfg_block_sync = 0; cfg_src_sync = 0;
    cfg_irq_en = 12'hFFF; status_clr = '0; ch_enable = 0; ch_disable = 0;
    req_vec = '0; xfer_done = 0; xfer_err = 0; xfer_misalign = 0;
    cur_req = "R1";
    tick(3);
    chk("R1", "reset outputs", 64'({ch_enabled, ch_active, load_err, status, elem_idx}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    tick(4);

    // R10: unsynchronised full block, E=4 F=2
    cur_req = "R10";
    setup(4, 2, 0, 0, 0, 0);
    chk("R4", "unsync active at enable", 64'(ch_active), 64'd1);
    strobe(8);
    chk("R10", "block-end status", 64'(status), 64'h03C);
    chk("R10", "enabled after block", 64'(ch_enabled), 64'd0);
    stop();

    // R3: illegal loads
    cur_req = "R3";
    setup(0, 5, 0, 0, 0, 0);
    chk("R3", "load_err zero elements", 64'(load_err), 64'd1);
    setup(3, 0, 0, 0, 0, 0);
    chk("R3", "enabled zero frames", 64'(ch_enabled), 64'd0);
    tick();

    // R7/R2: packet sync, length from destination side = 2
    cur_req = "R7";
    req_vec[5] = 1'b1; tick();
    setup(3, 2, 5, 1, 1, 0);
    chk("R4", "active with line high", 64'(ch_active), 64'd1);
    strobe();
    req_vec[5] = 1'b0;
    strobe();
    chk("R7", "inactive at packet wrap", 64'(ch_active), 64'd0);
    chk("R7", "packet status bit7", 64'(status[7]), 64'd1);
    cur_req = "R5";
    strobe();
    chk("R5", "strobe ignored while idle", 64'(elem_idx), 64'd2);
    cur_req = "R7";
    req_vec[5] = 1'b1; tick();
    strobe(4);
    stop();

    // R2: source-sync picks source length 3, no bit7
    cur_req = "R2";
    setup(9, 1, 0, 1, 1, 1);
    strobe(2);
    chk("R2", "packet index from source length", 64'(pkt_idx), 64'd2);
    strobe();
    chk("R7", "wrap without bit7 on source-sync", 64'({pkt_idx, status[7]}), 64'd0);
    chk("R6", "half-frame bit2", 64'(status[2]), 64'd0);
    strobe();
    chk("R6", "half-frame bit2 at 4 of 9", 64'(status[2]), 64'd1);
    stop();

    // R9: pending rise keeps one extra element
    cur_req = "R9";
    req_vec[9] = 1'b1;
    setup(8, 1, 9, 0, 0, 0);
    strobe();
    req_vec[9] = 1'b0; tick();
    req_vec[9] = 1'b1; tick();
    req_vec[9] = 1'b0; tick();
    strobe();
    chk("R9", "pending keeps active", 64'(ch_active), 64'd1);
    strobe();
    chk("R9", "falls once pending used", 64'(ch_active), 64'd0);
    // rise in same cycle as an attempt
    req_vec[9] = 1'b1; tick();
    req_vec[9] = 1'b0; tick();
    req_vec[9] = 1'b1; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    chk("R9", "same-cycle rise keeps active", 64'(ch_active), 64'd1);
    req_vec[9] = 1'b0;
    strobe();
    chk("R9", "pending consumed", 64'(ch_active), 64'd0);
    stop();

    // R8: frame sync E=2 F=3
    cur_req = "R8";
    setup(2, 3, 12, 1, 0, 0);
    chk("R4", "sync channel waits", 64'(ch_active), 64'd0);
    req_vec[12] = 1'b1; tick(); req_vec[12] = 1'b0; tick();
    strobe();
    chk("R8", "mid-frame stays", 64'(ch_active), 64'd1);
    strobe();
    chk("R8", "frame end drops", 64'({ch_active, frame_idx}), 64'h1);
    chk("R6", "frame bit3", 64'(status[3]), 64'd1);
    stop();

    // R7 collision: packet wrap on frame end, E=2 P=2
    cur_req = "R7";
    cfg_dst_fidx = 16'd2;
    setup(2, 3, 20, 1, 1, 0);
    req_vec[20] = 1'b1; tick(); req_vec[20] = 1'b0;
    strobe(2);
    chk("R7", "wrap and frame same cycle", 64'({ch_active, status[7], status[3]}), 64'b011);
    stop();

    // R11: mask and clear
    cur_req = "R11";
    cfg_irq_en = '0;
    setup(5, 1, 0, 0, 0, 0);
    xfer_err = 1'b1; xfer_misalign = 1'b1; tick(); xfer_err = 0; xfer_misalign = 0;
    chk("R11", "masked errors", 64'(status), 64'd0);
    cfg_irq_en = 12'h900;
    xfer_err = 1'b1; xfer_misalign = 1'b1; tick(); xfer_err = 0; xfer_misalign = 0;
    chk("R11", "error bits 8 and 11", 64'(status), 64'h900);
    status_clr = 12'h100; tick(); status_clr = '0;
    chk("R11", "w1c bit8", 64'(status), 64'h800);
    status_clr = 12'h800; xfer_misalign = 1'b1; tick(); xfer_misalign = 0; status_clr = '0;
    chk("R11", "set wins over clear", 64'(status), 64'h800);
    cfg_irq_en = 12'hFFF;
    stop();

    // R12: disable mid-transfer
    cur_req = "R12";
    setup(10, 1, 0, 0, 0, 0);
    strobe(2);
    ch_disable = 1'b1; ch_enable = 1'b1; tick(); ch_disable = 0; ch_enable = 0;
    chk("R12", "disable wins", 64'({ch_enabled, ch_active, elem_idx}), 64'd0);
    strobe();
    chk("R5", "strobe after disable", 64'(elem_idx), 64'd0);
    stop();

    // R4: selector out of range
    cur_req = "R4";
    req_vec = '1;
    setup(4, 1, 70, 0, 0, 0);
    tick(2);
    chk("R4", "selector 70 never active", 64'({ch_enabled, ch_active}), 64'b10);
    stop();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule